// File: doc/BRIEF.md
# Ethernet Transmit Framer with Pad and FCS Insertion

The block takes frame payload as a byte stream with valid/ready handshaking. It frames that payload for a byte-wide transmit output with a valid strobe. Each frame opens with a run of preamble octets, and the run length is configurable. One start-of-frame delimiter octet follows the run. The payload is then forwarded unchanged. Last, one of three tail policies is applied: nothing is added, a CRC-32 frame check sequence is added, or the frame is zero-padded to the Ethernet minimum and then the check sequence is added.

The tail policy normally comes from a configuration input. A frame can carry its own choice on sideband inputs that are sampled with the first payload byte. That choice applies to this frame only. While the block generates preamble, delimiter, pad or check octets by itself, it withholds `in_ready`, so the upstream source simply stalls.

The controller is a single state machine with these states: IDLE, PREAMBLE, SFD, PAYLOAD, PAD and FCS. Its transitions are:
- IDLE→PREAMBLE when a byte with its start marker is offered.
- PREAMBLE→SFD after the last preamble octet.
- SFD→PAYLOAD after the delimiter.
- PAYLOAD→IDLE on the end marker in pass-through mode.
- PAYLOAD→PAD on the end marker in padding mode when the frame is short.
- PAYLOAD→FCS on the end marker in any other mode that appends a check sequence.
- PAD→FCS once the padded length is reached.
- FCS→IDLE after the fourth check octet.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is held, and after reset with no input offered, `tx_valid` is 0 and `in_ready` is 0.
- R2: Each frame begins with N octets of 0x55. N is the value of `cfg_pre_len`, sampled when the frame starts. A value of 0 selects N = 7.
- R3: Exactly one octet 0xD5 follows the preamble and comes directly before the first payload byte.
- R4: Mode 2'b00 (pass-through): the output after the delimiter is exactly the payload, and nothing is appended.
- R5: Mode 2'b01: the payload is followed by a 4-octet FCS, sent least significant octet first. The FCS is CRC-32 with polynomial 0x04C11DB7 (reflected form), an initial value of all ones and a final inversion, computed over all bytes after the delimiter.
- R6: Modes 2'b10 and 2'b11: a payload shorter than 60 bytes is followed by 0x00 octets until payload plus pad is 60 bytes. A payload of 60 bytes or more is not padded. The FCS of R5 then follows, computed over payload and pad.
- R7: When `in_mode_ovr_en` is 1 together with the first (start-marked) byte, `in_mode_ovr` selects the mode for that frame. Changes to `cfg_mode` or to the override inputs later in the frame have no effect. A frame without override uses `cfg_mode`.
- R8: Payload bytes appear on the output in order and unchanged, including when the source leaves idle cycles between bytes.
- R9: `in_ready` is 0 while preamble, delimiter, pad or FCS octets are being produced. The first byte is therefore accepted only after N+2 stalled cycles.
- R10: While idle, a byte offered without a start marker is accepted (`in_ready` = 1) and dropped, and it produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pre_len | input | PRE_W | Preamble octet count (0 selects 7) |
| cfg_mode | input | 2 | Default tail mode: 00 raw, 01 FCS, 1x pad and FCS |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input payload byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_mode_ovr_en | input | 1 | Per-frame mode override enable, sampled with the first byte |
| in_mode_ovr | input | 2 | Per-frame mode, same encoding as cfg_mode |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| tx_valid | output | 1 | Output octet valid |
| tx_data | output | 8 | Output octet |

## Verification
Frames are sent under each tail mode with preamble lengths of 1, 7 (both programmed and selected by zero) and 15. The payload lengths are 1, short, exactly 60 and above 60. Comparing these separates padding to the minimum from padding that is wrongly applied to frames that are long enough, and separates a correctly reflected CRC from an error in octet order or in the final inversion. Some frames arrive with idle gaps, which shows whether a missing byte is mistaken for data. Other frames switch `cfg_mode` or the override inputs after the first byte, which shows whether the mode is latched once per frame. The stall count before the first byte and the `in_ready` level after the end marker distinguish correct back-pressure from a source that could overrun the block. Stray unmarked bytes between frames show whether idle input leaks onto the wire.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PREAMBLE = 3'd1,
        ST_SFD      = 3'd2,
        ST_PAYLOAD  = 3'd3,
        ST_PAD      = 3'd4,
        ST_FCS      = 3'd5
    } tx_state_e;

    typedef enum logic [1:0] {
        FM_RAW     = 2'b00,
        FM_FCS     = 2'b01,
        FM_PAD     = 2'b10,
        FM_PAD_ALT = 2'b11
    } frame_mode_e;

    localparam logic [7:0]  PRE_OCTET     = 8'h55;
    localparam logic [7:0]  SFD_OCTET     = 8'hD5;
    localparam logic [7:0]  PAD_OCTET     = 8'h00;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

    // One octet of the bit-reversed CRC-32 recurrence, LSB first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] fcs
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_q <= CRC_SEED;
        end else if (en) begin
            crc_q <= crc_step(crc_q, data);
        end
    end

    // Wire value: inverted remainder, sent low octet first by the controller.
    assign fcs = ~crc_q;

endmodule

// File: rtl/eth_tx_mode_latch.sv
module eth_tx_mode_latch
    import eth_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] cfg_mode,
    input  logic       ovr_en,
    input  logic [1:0] ovr_mode,
    output logic       fcs_en,
    output logic       pad_en
);

    frame_mode_e mode_q;
    frame_mode_e mode_sel;

    assign mode_sel = frame_mode_e'(ovr_en ? ovr_mode : cfg_mode);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= FM_RAW;
        end else if (start) begin
            mode_q <= mode_sel;
        end
    end

    always_comb begin
        fcs_en = 1'b0;
        pad_en = 1'b0;
        unique case (mode_q)
            FM_RAW:     begin fcs_en = 1'b0; pad_en = 1'b0; end
            FM_FCS:     begin fcs_en = 1'b1; pad_en = 1'b0; end
            FM_PAD:     begin fcs_en = 1'b1; pad_en = 1'b1; end
            FM_PAD_ALT: begin fcs_en = 1'b1; pad_en = 1'b1; end
            default:    begin fcs_en = 1'b0; pad_en = 1'b0; end
        endcase
    end

endmodule

// File: rtl/eth_tx_ctl.sv
module eth_tx_ctl
    import eth_tx_pkg::*;
#(
    parameter int PRE_W       = 4,
    parameter int PRE_DEFAULT = 7,
    parameter int MIN_FRAME   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] cfg_pre_len,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             fcs_en,
    input  logic             pad_en,
    input  logic [31:0]      fcs_word,
    output logic             in_ready,
    output logic             start,
    output logic             crc_clr,
    output logic             crc_en,
    output logic [7:0]       crc_byte,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output tx_state_e        state
);

    localparam int FCS_LEN    = 4;
    localparam int PAD_TARGET = MIN_FRAME - FCS_LEN;
    localparam int LEN_W      = $clog2(PAD_TARGET + 1);
    localparam int IDX_W      = $clog2(FCS_LEN);

    tx_state_e        state_q, state_d;
    logic [PRE_W-1:0] pre_cnt_q, pre_cnt_d, pre_load;
    logic [LEN_W-1:0] len_q, len_d, len_inc;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             emit;
    logic [7:0]       byte_c;
    logic             tx_valid_q;
    logic [7:0]       tx_data_q;

    assign pre_load = (cfg_pre_len == '0) ? PRE_W'(PRE_DEFAULT) : cfg_pre_len;
    assign len_inc  = (len_q == LEN_W'(PAD_TARGET)) ? len_q : len_q + LEN_W'(1);

    // Next state, counters and the octet to emit this cycle.
    always_comb begin
        state_d   = state_q;
        pre_cnt_d = pre_cnt_q;
        len_d     = len_q;
        idx_d     = idx_q;
        in_ready  = 1'b0;
        start     = 1'b0;
        emit      = 1'b0;
        crc_en    = 1'b0;
        byte_c    = PAD_OCTET;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = in_valid & ~in_sof;
                len_d    = '0;
                idx_d    = '0;
                if (in_valid && in_sof) begin
                    start     = 1'b1;
                    pre_cnt_d = pre_load;
                    state_d   = ST_PREAMBLE;
                end
            end
            ST_PREAMBLE: begin
                emit      = 1'b1;
                byte_c    = PRE_OCTET;
                pre_cnt_d = pre_cnt_q - PRE_W'(1);
                if (pre_cnt_q == PRE_W'(1)) begin
                    state_d = ST_SFD;
                end
            end
            ST_SFD: begin
                emit    = 1'b1;
                byte_c  = SFD_OCTET;
                state_d = ST_PAYLOAD;
            end
            ST_PAYLOAD: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    emit   = 1'b1;
                    crc_en = 1'b1;
                    byte_c = in_data;
                    len_d  = len_inc;
                    if (in_eof) begin
                        if (!fcs_en) begin
                            state_d = ST_IDLE;
                        end else if (pad_en && (len_inc < LEN_W'(PAD_TARGET))) begin
                            state_d = ST_PAD;
                        end else begin
                            state_d = ST_FCS;
                        end
                    end
                end
            end
            ST_PAD: begin
                emit   = 1'b1;
                crc_en = 1'b1;
                byte_c = PAD_OCTET;
                len_d  = len_inc;
                if (len_inc == LEN_W'(PAD_TARGET)) begin
                    state_d = ST_FCS;
                end
            end
            ST_FCS: begin
                emit   = 1'b1;
                byte_c = fcs_word[{idx_q, 3'b000} +: 8];
                idx_d  = idx_q + IDX_W'(1);
                if (idx_q == IDX_W'(FCS_LEN - 1)) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pre_cnt_q <= '0;
            len_q     <= '0;
            idx_q     <= '0;
        end else begin
            state_q   <= state_d;
            pre_cnt_q <= pre_cnt_d;
            len_q     <= len_d;
            idx_q     <= idx_d;
        end
    end

    // Registered output octet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid_q <= 1'b0;
            tx_data_q  <= '0;
        end else begin
            tx_valid_q <= emit;
            tx_data_q  <= emit ? byte_c : '0;
        end
    end

    assign crc_clr  = (state_q == ST_IDLE);
    assign crc_byte = byte_c;
    assign tx_valid = tx_valid_q;
    assign tx_data  = tx_data_q;
    assign state    = state_q;

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
    import eth_tx_pkg::*;
#(
    parameter int PRE_W       = 4,
    parameter int PRE_DEFAULT = 7,
    parameter int MIN_FRAME   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] cfg_pre_len,
    input  logic [1:0]       cfg_mode,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             in_mode_ovr_en,
    input  logic [1:0]       in_mode_ovr,
    output logic             in_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data
);

    logic        start_w;
    logic        fcs_en_w;
    logic        pad_en_w;
    logic        crc_clr_w;
    logic        crc_en_w;
    logic [7:0]  crc_byte_w;
    logic [31:0] fcs_w;
    tx_state_e   state_w;

    eth_tx_mode_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_w),
        .cfg_mode (cfg_mode),
        .ovr_en   (in_mode_ovr_en),
        .ovr_mode (in_mode_ovr),
        .fcs_en   (fcs_en_w),
        .pad_en   (pad_en_w)
    );

    eth_tx_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr_w),
        .en    (crc_en_w),
        .data  (crc_byte_w),
        .fcs   (fcs_w)
    );

    eth_tx_ctl #(
        .PRE_W       (PRE_W),
        .PRE_DEFAULT (PRE_DEFAULT),
        .MIN_FRAME   (MIN_FRAME)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_pre_len (cfg_pre_len),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_sof      (in_sof),
        .in_eof      (in_eof),
        .fcs_en      (fcs_en_w),
        .pad_en      (pad_en_w),
        .fcs_word    (fcs_w),
        .in_ready    (in_ready),
        .start       (start_w),
        .crc_clr     (crc_clr_w),
        .crc_en      (crc_en_w),
        .crc_byte    (crc_byte_w),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .state       (state_w)
    );

endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk
    import eth_tx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       in_ready,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input tx_state_e  state
);

    a_r2_preamble_octet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREAMBLE) |=> (tx_valid && tx_data == 8'h55));

    a_r3_sfd_octet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SFD) |=> (tx_valid && tx_data == 8'hD5));

    a_r6_pad_octet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD) |=> (tx_valid && tx_data == 8'h00));

    a_r8_payload_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAYLOAD && in_valid && in_ready) |=> (tx_valid && tx_data == $past(in_data)));

    a_r9_ready_withheld: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREAMBLE || state == ST_SFD || state == ST_PAD || state == ST_FCS) |-> !in_ready);

    a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !tx_valid);

endmodule

bind eth_tx_framer eth_tx_framer_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .state    (state_w)
);

// File: tb/test_eth_tx_framer.sv
module test_eth_tx_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_pre_len = 4'd0;
    logic [1:0] cfg_mode = 2'b00;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       in_mode_ovr_en = 1'b0;
    logic [1:0] in_mode_ovr = 2'b00;
    logic       in_ready;
    logic       tx_valid;
    logic [7:0] tx_data;

    always #5 clk = ~clk;

    eth_tx_framer i_eth_tx_framer (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_pre_len    (cfg_pre_len),
        .cfg_mode       (cfg_mode),
        .in_valid       (in_valid),
        .in_data        (in_data),
        .in_sof         (in_sof),
        .in_eof         (in_eof),
        .in_mode_ovr_en (in_mode_ovr_en),
        .in_mode_ovr    (in_mode_ovr),
        .in_ready       (in_ready),
        .tx_valid       (tx_valid),
        .tx_data        (tx_data)
    );

    // Stimulus table: preamble, cfg mode, override enable/mode, length, gaps, mid-frame cfg change.
    localparam int NROWS = 9;
    localparam int V_PRE  [NROWS] = '{7, 0, 3, 1, 15, 2, 5, 4, 7};
    localparam int V_MODE [NROWS] = '{1, 0, 2, 2, 2, 0, 2, 1, 3};
    localparam int V_OEN  [NROWS] = '{0, 0, 0, 0, 0, 1, 1, 0, 0};
    localparam int V_OVR  [NROWS] = '{0, 0, 0, 0, 0, 2, 0, 0, 0};
    localparam int V_LEN  [NROWS] = '{10, 5, 20, 60, 70, 1, 8, 59, 3};
    localparam int V_GAP  [NROWS] = '{0, 0, 1, 0, 0, 0, 1, 0, 1};
    localparam int V_CHG  [NROWS] = '{0, 0, 0, 0, 0, 0, 0, 1, 0};

    int errors = 0;
    int checks = 0;
    int got_total = 0;
    logic [7:0] got [256];
    logic [7:0] exp_b [256];
    int exp_n;

    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            got[got_total % 256] = tx_data;
            got_total = got_total + 1;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(input int r, input int i);
        return 8'((r * 29 + 3) + i * 13);
    endfunction

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] x;
        x = c ^ {24'd0, d};
        for (int b = 0; b < 8; b++) x = x[0] ? ((x >> 1) ^ 32'hEDB88320) : (x >> 1);
        return x;
    endfunction

    task automatic build(input int r);
        int pl;
        int md;
        int body;
        logic [31:0] c;
        pl = (V_PRE[r] == 0) ? 7 : V_PRE[r];
        md = V_OEN[r] ? V_OVR[r] : V_MODE[r];
        exp_n = 0;
        for (int k = 0; k < pl; k++) begin exp_b[exp_n] = 8'h55; exp_n++; end
        exp_b[exp_n] = 8'hD5; exp_n++;
        body = V_LEN[r];
        if (md >= 2 && body < 60) body = 60;
        c = 32'hFFFFFFFF;
        for (int k = 0; k < body; k++) begin
            logic [7:0] b;
            b = (k < V_LEN[r]) ? pay(r, k) : 8'h00;
            c = crc_upd(c, b);
            exp_b[exp_n] = b;
            exp_n++;
        end
        if (md != 0) begin
            for (int k = 0; k < 4; k++) begin exp_b[exp_n] = 8'(~c >> (8 * k)); exp_n++; end
        end
    endtask

    task automatic run_row(input int r);
        int base;
        int wait_n;
        int bad;
        int idle_bad;
        int first_bad;
        int pl;
        string req;
        build(r);
        pl = (V_PRE[r] == 0) ? 7 : V_PRE[r];
        @(negedge clk);
        cfg_pre_len = 4'(V_PRE[r]);
        cfg_mode = 2'(V_MODE[r]);
        #1;
        base = got_total;
        wait_n = 0;
        for (int i = 0; i < V_LEN[r]; i++) begin
            bit done;
            done = 1'b0;
            if (V_GAP[r] != 0 && i > 0 && i % 3 == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data = 8'hA5;
            end
            while (!done) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_sof = (i == 0);
                in_eof = (i == V_LEN[r] - 1);
                in_data = pay(r, i);
                in_mode_ovr_en = (i == 0) ? 1'(V_OEN[r]) : ~1'(V_OEN[r]);
                in_mode_ovr = 2'(V_OVR[r]) ^ ((i == 0) ? 2'b00 : 2'b01);
                if (V_CHG[r] != 0 && i > 0) cfg_mode = 2'b00;
                #1;
                done = in_ready;
                @(posedge clk);
                if (!done && i == 0) wait_n++;
            end
        end
        // R9: stalls before the first byte cover preamble and delimiter
        chk(wait_n == pl + 2, "R9", $sformatf("row %0d stall cycles before first byte", r), wait_n, pl + 2);
        // R9: no byte taken while pad/FCS drain, source keeps offering unmarked bytes
        bad = 0;
        for (int g = 0; g < 200; g++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'hEE;
            #1;
            if (got_total - base >= exp_n) break;
            if (in_ready) bad++;
        end
        chk(bad == 0, "R9", $sformatf("row %0d ready cycles during tail", r), bad, 0);
        // R10: unmarked bytes while idle are taken and dropped
        idle_bad = 0;
        for (int g = 0; g < 3; g++) begin
            @(negedge clk);
            #1;
            if (!in_ready) idle_bad++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_mode_ovr_en = 1'b0;
        cfg_mode = 2'(V_MODE[r]);
        chk(idle_bad == 0, "R10", $sformatf("row %0d idle drop ready misses", r), idle_bad, 0);
        repeat (3) @(negedge clk);
        #1;
        chk(got_total - base == exp_n, "R10", $sformatf("row %0d output octet count", r), got_total - base, exp_n);
        first_bad = -1;
        for (int k = 0; k < exp_n; k++) begin
            if (first_bad < 0 && got[(base + k) % 256] !== exp_b[k]) first_bad = k;
        end
        if (V_CHG[r] != 0) req = "R7";
        else if (V_OEN[r] != 0) req = "R7";
        else if (V_GAP[r] != 0) req = "R8";
        else if (V_MODE[r] == 0) req = "R4";
        else if (V_MODE[r] == 1) req = "R5";
        else req = "R6";
        if (first_bad < 0) begin
            chk(1'b1, req, "frame content", 0, 0);
        end else begin
            chk(1'b0, req, $sformatf("row %0d octet %0d", r, first_bad),
                int'(got[(base + first_bad) % 256]), int'(exp_b[first_bad]));
        end
        // R2/R3: header octets in their own check
        first_bad = 0;
        for (int k = 0; k <= pl; k++) begin
            if (got[(base + k) % 256] !== exp_b[k]) first_bad++;
        end
        chk(first_bad == 0, "R2", $sformatf("row %0d preamble+delimiter mismatches (R3)", r), first_bad, 0);
    endtask

    initial begin
        // R1: reset state, even with a start-marked byte offered
        in_valid = 1'b1; in_sof = 1'b1; in_data = 8'h11;
        repeat (3) @(negedge clk);
        #1;
        chk(tx_valid == 1'b0, "R1", "tx_valid in reset", int'(tx_valid), 0);
        chk(in_ready == 1'b0, "R1", "in_ready in reset", int'(in_ready), 0);
        in_valid = 1'b0; in_sof = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(tx_valid == 1'b0 && in_ready == 1'b0, "R1", "idle after reset",
            int'({tx_valid, in_ready}), 0);
        for (int r = 0; r < NROWS; r++) run_row(r);
        summary();
        $finish;
    end

endmodule